// File: doc/BRIEF.md
# SDH Transport Overhead Inserter

This block produces an STS-3c / STM-1 byte stream for an add bus. The frame has 9 rows of 270 byte columns. The first 9 columns of every row carry transport overhead and the other 261 columns carry payload. The block generates the framing, C1 and pointer overhead itself. It takes payload bytes from an upstream source through a valid/ready handshake and places them in the payload columns. On the bus it drives:

- a clock
- a combined C1/J1 marker
- a payload (SPE) indicator
- the byte data with an output-enable
- an odd parity bit
- an add strobe

The frame position can come from three timing sources, selected by `cfg_tmode`:

- **Free-running (00):** the internal counters wrap on their own.
- **External (01):** an external frame pulse reloads the position with a programmable row/column offset, so a pulse may be placed anywhere within one frame.
- **Slaved (10):** a C1 marker seen on the incoming bus reloads the position. In this mode, two watchdogs check that the sampled bus clock and the incoming marker keep toggling.

Software-set values arrive as static configuration inputs:

- C1 value
- pointer SS bits
- whether unused overhead is undriven or zero
- parity coverage
- frame-pulse offset

Top module: `sdh_toh_inserter`

## Requirements
- R1: While reset is asserted, add_data, add_data_oe, add_en, add_c1j1, add_spe, add_par and both alarms are 0. After release, the first output byte is row 0, column 0. Every output byte appears one clock after its position is counted.
- R2: Row 0 carries 0xF6 in columns 0..2 and 0x28 in columns 3..5, all driven.
- R3: Row 0 columns 6..7..8 carry B, B+1, B+2. B is 0x01 when cfg_c1_prog=0 and cfg_c1_val when 1. add_c1j1 is high only at row 0 column 6 within the overhead.
- R4: Row 3 carries the pointer bytes:
  - column 0: H1 = {0110, SS, 00}, where SS is 10 when cfg_ss_prog=0 and cfg_ss_val when 1
  - column 3: H2 = 0x00
  - columns 1 and 2: 0x93
  - columns 4 and 5: 0xFF
- R5: In columns 9..269, add_spe=1 and pl_ready=1. add_data is the pl_data sampled with that position when pl_valid=1, and 0 when pl_valid=0. add_c1j1 is high at row 3 column 9 (J1, fixed pointer 0).
- R6: The other overhead positions (rows 1, 2 and 4..8 in columns 0..8, and row 3 columns 6..8) carry data 0, add_c1j1=0 and add_spe=0. add_data_oe=add_en=1 when cfg_unused_hiz=0, and add_data_oe=add_en=0 when it is 1. add_en equals add_data_oe on every byte.
- R7: add_par gives odd parity. When cfg_par_all=1 it covers {add_data, add_c1j1, add_spe, add_par}. When cfg_par_all=0 it covers {add_data, add_par}.
- R8: With cfg_tmode=00 the position runs through 2430 bytes and repeats, and ext_fp and bus_c1j1 have no effect.
- R9: With cfg_tmode=01, an ext_fp high at a clock edge makes the byte shown two edges later the one at (cfg_off_row, cfg_off_col). Offsets must be in range. Counting then continues from there.
- R10: With cfg_tmode=10, bus_c1j1=1 with bus_spe=0 at an edge makes the byte two edges later the row 0 column 6 byte. bus_c1j1=1 with bus_spe=1 has no effect on the position.
- R11: With cfg_tmode=10, alm_clk_loss rises once bus_clk_smp has been unchanged for CLK_LIMIT (16) clocks. It clears after the next change. It is 0 in other modes.
- R12: With cfg_tmode=10, alm_mk_loss rises once no rising edge of bus_c1j1 has occurred for two frame times (4860 clocks). It clears after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tmode | input | 2 | Timing source: 00 free, 01 external pulse, 10 bus slaved |
| cfg_off_row | input | 4 | Row loaded by an external frame pulse |
| cfg_off_col | input | 9 | Column loaded by an external frame pulse |
| cfg_c1_prog | input | 1 | Select programmed C1 base |
| cfg_c1_val | input | 8 | Programmed C1 base |
| cfg_ss_prog | input | 1 | Select programmed SS bits |
| cfg_ss_val | input | 2 | Programmed SS bits |
| cfg_unused_hiz | input | 1 | Leave unused overhead undriven |
| cfg_par_all | input | 1 | Parity over data, marker and SPE flag instead of data alone |
| ext_fp | input | 1 | External frame pulse |
| bus_clk_smp | input | 1 | Incoming bus clock, sampled |
| bus_c1j1 | input | 1 | Incoming C1/J1 marker |
| bus_spe | input | 1 | Incoming SPE indicator |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte taken this cycle |
| add_clk | output | 1 | Add bus clock |
| add_c1j1 | output | 1 | C1/J1 marker |
| add_spe | output | 1 | SPE indicator |
| add_data | output | 8 | Byte data |
| add_data_oe | output | 1 | Data output enable |
| add_par | output | 1 | Odd parity |
| add_en | output | 1 | Add strobe |
| alm_clk_loss | output | 1 | Bus clock stopped |
| alm_mk_loss | output | 1 | Bus marker missing |

## Verification
A wrong position count shifts the framing bytes, the C1/J1 markers and the SPE flag. It shows at the first misplaced byte, always within one 2430-clock frame and within one byte of a timing reload. A fault in a configuration mux shows at a fixed byte in row 0 or row 3 in the first frame after the setting changes. Wrong parity coverage fails on nearly every byte. An off-by-n in either watchdog moves the alarm edge by n clocks around its limit, so the alarm is checked just before and just after that edge.

// File: rtl/sdh_ins_pkg.sv
package sdh_ins_pkg;
    localparam int unsigned FR_ROWS = 9;
    localparam int unsigned FR_COLS = 270;
    localparam int unsigned FR_TOH  = 9;

    localparam logic [7:0] A1_BYTE    = 8'hF6;
    localparam logic [7:0] A2_BYTE    = 8'h28;
    localparam logic [7:0] C1_DEFAULT = 8'h01;
    localparam logic [7:0] CAT_H1     = 8'h93;
    localparam logic [7:0] CAT_H2     = 8'hFF;
    localparam logic [1:0] SS_DEFAULT = 2'b10;
    localparam logic [3:0] NDF_NORMAL = 4'b0110;

    typedef enum logic [1:0] {
        TM_FREE = 2'd0,
        TM_EXT  = 2'd1,
        TM_BUS  = 2'd2
    } tmode_e;

    typedef struct packed {
        logic [7:0] data;
        logic       oe;
        logic       c1j1;
        logic       spe;
        logic       par;
    } addbyte_t;
endpackage

// File: rtl/sdh_ins_timer.sv
module sdh_ins_timer
    import sdh_ins_pkg::*;
#(
    parameter int unsigned ROWS   = FR_ROWS,
    parameter int unsigned COLS   = FR_COLS,
    parameter int unsigned ROW_W  = $clog2(ROWS),
    parameter int unsigned COL_W  = $clog2(COLS),
    parameter int unsigned C1_ROW = 0,
    parameter int unsigned C1_COL = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             ext_fp,
    input  logic [ROW_W-1:0] off_row,
    input  logic [COL_W-1:0] off_col,
    input  logic             bus_c1j1,
    input  logic             bus_spe,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.col == COL_W'(COLS - 1)) begin
            pos_d.col = '0;
            pos_d.row = (pos_q.row == ROW_W'(ROWS - 1)) ? '0 : pos_q.row + 1'b1;
        end else begin
            pos_d.col = pos_q.col + 1'b1;
        end
        if (mode == TM_EXT && ext_fp) begin
            pos_d.row = off_row;
            pos_d.col = off_col;
        end else if (mode == TM_BUS && bus_c1j1 && !bus_spe) begin
            pos_d.row = ROW_W'(C1_ROW);
            pos_d.col = COL_W'(C1_COL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign row = pos_q.row;
    assign col = pos_q.col;

    // R8
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q.col < COL_W'(COLS)) && (pos_q.row < ROW_W'(ROWS)));

    // R8
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_FREE && pos_q.col == COL_W'(COLS - 1)) |=> (pos_q.col == '0));

    // R9
    ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_EXT && ext_fp) |=>
            (pos_q.row == $past(off_row) && pos_q.col == $past(off_col)));

    // R10
    bus_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_BUS && bus_c1j1 && !bus_spe) |=>
            (pos_q.row == ROW_W'(C1_ROW) && pos_q.col == COL_W'(C1_COL)));
endmodule

// File: rtl/sdh_ins_byte_gen.sv
module sdh_ins_byte_gen
    import sdh_ins_pkg::*;
#(
    parameter int unsigned ROW_W    = 4,
    parameter int unsigned COL_W    = 9,
    parameter int unsigned TOH_COLS = FR_TOH,
    parameter int unsigned PTR_ROW  = 3,
    parameter logic [9:0]  PTR_VAL  = 10'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             cfg_c1_prog,
    input  logic [7:0]       cfg_c1_val,
    input  logic             cfg_ss_prog,
    input  logic [1:0]       cfg_ss_val,
    input  logic             cfg_unused_hiz,
    input  logic             cfg_par_all,
    input  logic             pl_valid,
    input  logic [7:0]       pl_data,
    output logic             pl_ready,
    output addbyte_t         out
);
    addbyte_t   out_d, out_q;
    logic       in_spe;
    logic [7:0] c1_base;
    logic [1:0] ss_bits;

    always_comb begin
        in_spe  = (col >= COL_W'(TOH_COLS));
        c1_base = cfg_c1_prog ? cfg_c1_val : C1_DEFAULT;
        ss_bits = cfg_ss_prog ? cfg_ss_val : SS_DEFAULT;
        out_d   = '0;
        if (in_spe) begin
            out_d.data = pl_valid ? pl_data : 8'h00;
            out_d.oe   = 1'b1;
            out_d.spe  = 1'b1;
            out_d.c1j1 = (row == ROW_W'(PTR_ROW)) && (col == COL_W'(TOH_COLS));
        end else if (row == '0) begin
            out_d.oe = 1'b1;
            if (col < COL_W'(3))      out_d.data = A1_BYTE;
            else if (col < COL_W'(6)) out_d.data = A2_BYTE;
            else                      out_d.data = c1_base + 8'(col) - 8'd6;
            out_d.c1j1 = (col == COL_W'(6));
        end else if (row == ROW_W'(PTR_ROW) && col < COL_W'(6)) begin
            out_d.oe = 1'b1;
            if (col == '0)            out_d.data = {NDF_NORMAL, ss_bits, PTR_VAL[9:8]};
            else if (col < COL_W'(3)) out_d.data = CAT_H1;
            else if (col == COL_W'(3)) out_d.data = PTR_VAL[7:0];
            else                      out_d.data = CAT_H2;
        end else begin
            out_d.oe = !cfg_unused_hiz;
        end
        out_d.par = cfg_par_all ? ~^{out_d.data, out_d.c1j1, out_d.spe} : ~^out_d.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pl_ready = in_spe;
    assign out      = out_q;

    // R5
    ready_spe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |=> out_q.spe);

    // R7
    par_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_par_all)) |->
            (^{out_q.data, out_q.c1j1, out_q.spe, out_q.par}));

    // R7
    par_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_par_all)) |-> (^{out_q.data, out_q.par}));

    // R6
    undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.oe |-> (out_q.data == 8'h00 && !out_q.spe && !out_q.c1j1));
endmodule

// File: rtl/sdh_ins_wdog.sv
module sdh_ins_wdog #(
    parameter int unsigned LIMIT     = 16,
    parameter bit          RISE_ONLY = 1'b0,
    parameter int unsigned CNT_W     = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sig,
    output logic alarm
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } wd_t;

    wd_t  wd_d, wd_q;
    logic seen;

    always_comb begin
        seen      = RISE_ONLY ? (sig && !wd_q.prev) : (sig ^ wd_q.prev);
        wd_d.prev = sig;
        if (!en || seen)                    wd_d.cnt = '0;
        else if (wd_q.cnt == CNT_W'(LIMIT)) wd_d.cnt = wd_q.cnt;
        else                                wd_d.cnt = wd_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign alarm = (wd_q.cnt == CNT_W'(LIMIT));

    // R11, R12
    edge_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && seen) |=> !alarm);

    // R11, R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !alarm);
endmodule

// File: rtl/sdh_toh_inserter.sv
module sdh_toh_inserter
    import sdh_ins_pkg::*;
#(
    parameter int unsigned ROWS      = FR_ROWS,
    parameter int unsigned COLS      = FR_COLS,
    parameter int unsigned TOH_COLS  = FR_TOH,
    parameter int unsigned CLK_LIMIT = 16,
    parameter int unsigned ROW_W     = $clog2(ROWS),
    parameter int unsigned COL_W     = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_tmode,
    input  logic [ROW_W-1:0] cfg_off_row,
    input  logic [COL_W-1:0] cfg_off_col,
    input  logic             cfg_c1_prog,
    input  logic [7:0]       cfg_c1_val,
    input  logic             cfg_ss_prog,
    input  logic [1:0]       cfg_ss_val,
    input  logic             cfg_unused_hiz,
    input  logic             cfg_par_all,
    input  logic             ext_fp,
    input  logic             bus_clk_smp,
    input  logic             bus_c1j1,
    input  logic             bus_spe,
    input  logic             pl_valid,
    input  logic [7:0]       pl_data,
    output logic             pl_ready,
    output logic             add_clk,
    output logic             add_c1j1,
    output logic             add_spe,
    output logic [7:0]       add_data,
    output logic             add_data_oe,
    output logic             add_par,
    output logic             add_en,
    output logic             alm_clk_loss,
    output logic             alm_mk_loss
);
    localparam int unsigned MK_LIMIT = 2 * ROWS * COLS;

    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    addbyte_t         ob;
    logic             slaved;

    assign slaved = (cfg_tmode == TM_BUS);

    sdh_ins_timer #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .mode(cfg_tmode), .ext_fp(ext_fp),
        .off_row(cfg_off_row), .off_col(cfg_off_col),
        .bus_c1j1(bus_c1j1), .bus_spe(bus_spe), .row(row), .col(col)
    );

    sdh_ins_byte_gen #(.ROW_W(ROW_W), .COL_W(COL_W), .TOH_COLS(TOH_COLS)) u_gen (
        .clk(clk), .rst_n(rst_n), .row(row), .col(col),
        .cfg_c1_prog(cfg_c1_prog), .cfg_c1_val(cfg_c1_val),
        .cfg_ss_prog(cfg_ss_prog), .cfg_ss_val(cfg_ss_val),
        .cfg_unused_hiz(cfg_unused_hiz), .cfg_par_all(cfg_par_all),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready), .out(ob)
    );

    sdh_ins_wdog #(.LIMIT(CLK_LIMIT), .RISE_ONLY(1'b0)) u_clk_wd (
        .clk(clk), .rst_n(rst_n), .en(slaved), .sig(bus_clk_smp), .alarm(alm_clk_loss)
    );

    sdh_ins_wdog #(.LIMIT(MK_LIMIT), .RISE_ONLY(1'b1)) u_mk_wd (
        .clk(clk), .rst_n(rst_n), .en(slaved), .sig(bus_c1j1), .alarm(alm_mk_loss)
    );

    assign add_clk     = clk;
    assign add_data    = ob.data;
    assign add_data_oe = ob.oe;
    assign add_en      = ob.oe;
    assign add_c1j1    = ob.c1j1;
    assign add_spe     = ob.spe;
    assign add_par     = ob.par;
endmodule

// File: tb/sdh_toh_inserter_bench.sv
module sdh_toh_inserter_bench;
    import sdh_ins_pkg::*;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_tmode = 2'd0;
    logic [3:0] cfg_off_row = '0;
    logic [8:0] cfg_off_col = '0;
    logic       cfg_c1_prog = 1'b0;
    logic [7:0] cfg_c1_val = 8'h00;
    logic       cfg_ss_prog = 1'b0;
    logic [1:0] cfg_ss_val = 2'b00;
    logic       cfg_unused_hiz = 1'b0;
    logic       cfg_par_all = 1'b1;
    logic       ext_fp = 1'b0;
    logic       bus_clk_smp = 1'b0;
    logic       bus_c1j1 = 1'b0;
    logic       bus_spe = 1'b0;
    logic       pl_valid = 1'b1;
    logic [7:0] pl_data = 8'hA5;
    logic       pl_ready, add_clk, add_c1j1, add_spe, add_data_oe, add_par, add_en;
    logic [7:0] add_data;
    logic       alm_clk_loss, alm_mk_loss;

    sdh_toh_inserter u_sdh_toh_inserter (
        .clk(clk), .rst_n(rst_n), .cfg_tmode(cfg_tmode),
        .cfg_off_row(cfg_off_row), .cfg_off_col(cfg_off_col),
        .cfg_c1_prog(cfg_c1_prog), .cfg_c1_val(cfg_c1_val),
        .cfg_ss_prog(cfg_ss_prog), .cfg_ss_val(cfg_ss_val),
        .cfg_unused_hiz(cfg_unused_hiz), .cfg_par_all(cfg_par_all),
        .ext_fp(ext_fp), .bus_clk_smp(bus_clk_smp), .bus_c1j1(bus_c1j1), .bus_spe(bus_spe),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
        .add_clk(add_clk), .add_c1j1(add_c1j1), .add_spe(add_spe), .add_data(add_data),
        .add_data_oe(add_data_oe), .add_par(add_par), .add_en(add_en),
        .alm_clk_loss(alm_clk_loss), .alm_mk_loss(alm_mk_loss)
    );

    always #(CLK_P / 2) clk = ~clk;

    int       n_checks = 0;
    int       n_fails  = 0;
    int       er = 0;
    int       ec = 0;
    string    cur_tag = "R1";
    bit       tog_en = 1'b0;
    addbyte_t exp_q[$];

    always @(negedge clk) if (tog_en) bus_clk_smp <= ~bus_clk_smp;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, expv);
        end
    endtask

    function automatic addbyte_t exp_at(int r, int c);
        addbyte_t   e;
        logic [7:0] b;
        logic [1:0] s;
        b = cfg_c1_prog ? cfg_c1_val : 8'h01;
        s = cfg_ss_prog ? cfg_ss_val : 2'b10;
        e = '0;
        if (c >= 9) begin
            e.oe = 1'b1; e.spe = 1'b1;
            e.data = pl_valid ? pl_data : 8'h00;
            e.c1j1 = (r == 3 && c == 9);
        end else if (r == 0) begin
            e.oe = 1'b1;
            if (c < 3)      e.data = 8'hF6;
            else if (c < 6) e.data = 8'h28;
            else            e.data = b + 8'(c - 6);
            e.c1j1 = (c == 6);
        end else if (r == 3 && c < 6) begin
            e.oe = 1'b1;
            case (c)
                0:       e.data = {4'b0110, s, 2'b00};
                1, 2:    e.data = 8'h93;
                3:       e.data = 8'h00;
                default: e.data = 8'hFF;
            endcase
        end else begin
            e.oe = !cfg_unused_hiz;
        end
        e.par = cfg_par_all ? ~^{e.data, e.c1j1, e.spe} : ~^e.data;
        return e;
    endfunction

    // monitor: pops one expected byte per output cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            addbyte_t e;
            e = exp_q.pop_front();
            chk($sformatf("%s byte", cur_tag),
                {20'd0, add_data, add_data_oe, add_en, add_c1j1, add_spe, add_par},
                {20'd0, e.data, e.oe, e.oe, e.c1j1, e.spe, e.par});
        end
    end

    // driver: pushes the expectation for n consecutive output bytes
    task automatic expect_seq(int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(exp_at(er, ec));
            ec++;
            if (ec == 270) begin
                ec = 0;
                er = (er == 8) ? 0 : er + 1;
            end
        end
        wait (exp_q.size() == 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: act=hung exp=finished");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 reset outputs",
            {20'd0, add_data, add_data_oe, add_en, add_c1j1, add_spe, add_par, alm_clk_loss, alm_mk_loss},
            32'd0);
        #(CLK_P / 4);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R8: default config, free-running, more than one frame
        cur_tag = "R1/R2/R3/R4/R5/R8";
        expect_seq(2430 + 20);

        // R8: ext pulse and bus marker ignored in free mode
        cur_tag = "R8 ignore";
        ext_fp = 1'b1; bus_c1j1 = 1'b1;
        cfg_off_row = 4'd5; cfg_off_col = 9'd100;
        expect_seq(1);
        ext_fp = 1'b0; bus_c1j1 = 1'b0;
        expect_seq(200);

        // R3 R4 R6 R7: programmed C1/SS, undriven unused overhead, data-only parity
        cur_tag = "R3/R4/R6/R7 prog";
        cfg_c1_prog = 1'b1; cfg_c1_val = 8'h40;
        cfg_ss_prog = 1'b1; cfg_ss_val = 2'b01;
        cfg_unused_hiz = 1'b1; cfg_par_all = 1'b0;
        pl_data = 8'h3C;
        expect_seq(2430);

        // R5 R6 R7: idle payload, driven-zero overhead, full parity
        cur_tag = "R5/R6/R7 idle";
        cfg_unused_hiz = 1'b0; cfg_par_all = 1'b1;
        pl_valid = 1'b0; cfg_c1_prog = 1'b0; cfg_ss_prog = 1'b0;
        expect_seq(2430);

        // R9: external frame pulse with offset
        cur_tag = "R9 ext";
        pl_valid = 1'b1; pl_data = 8'h81;
        cfg_tmode = 2'd1;
        expect_seq(10);
        ext_fp = 1'b1;
        expect_seq(1);
        ext_fp = 1'b0; er = 5; ec = 100;
        expect_seq(3000);
        cfg_off_row = 4'd8; cfg_off_col = 9'd269;
        ext_fp = 1'b1;
        expect_seq(1);
        ext_fp = 1'b0; er = 8; ec = 269;
        expect_seq(50);

        // R10: bus slaved timing
        cur_tag = "R10 bus";
        cfg_tmode = 2'd2; tog_en = 1'b1;
        bus_c1j1 = 1'b1; bus_spe = 1'b1;
        expect_seq(1);
        bus_c1j1 = 1'b0; bus_spe = 1'b0;
        expect_seq(20);
        bus_c1j1 = 1'b1;
        expect_seq(1);
        bus_c1j1 = 1'b0; er = 0; ec = 6;
        expect_seq(2429);
        bus_c1j1 = 1'b1;
        expect_seq(1);
        bus_c1j1 = 1'b0; er = 0; ec = 6;
        expect_seq(1000);
        chk("R11 clock present", {31'd0, alm_clk_loss}, 32'd0);
        chk("R12 marker present", {31'd0, alm_mk_loss}, 32'd0);

        // R11: stop the sampled bus clock
        cur_tag = "R11 run";
        tog_en = 1'b0;
        expect_seq(12);
        chk("R11 before limit", {31'd0, alm_clk_loss}, 32'd0);
        expect_seq(10);
        chk("R11 after limit", {31'd0, alm_clk_loss}, 32'd1);
        tog_en = 1'b1;
        expect_seq(5);
        chk("R11 cleared", {31'd0, alm_clk_loss}, 32'd0);

        // R12: marker missing for two frames
        cur_tag = "R12 run";
        bus_c1j1 = 1'b1;
        expect_seq(1);
        bus_c1j1 = 1'b0; er = 0; ec = 6;
        expect_seq(4840);
        chk("R12 before limit", {31'd0, alm_mk_loss}, 32'd0);
        expect_seq(40);
        chk("R12 after limit", {31'd0, alm_mk_loss}, 32'd1);
        bus_c1j1 = 1'b1;
        expect_seq(1);
        bus_c1j1 = 1'b0; er = 0; ec = 6;
        expect_seq(5);
        chk("R12 cleared", {31'd0, alm_mk_loss}, 32'd0);

        // R11 R12: alarms quiet outside slaved mode
        tog_en = 1'b0; cfg_tmode = 2'd0;
        cur_tag = "R8 free again";
        expect_seq(40);
        chk("R11 off in free mode", {31'd0, alm_clk_loss}, 32'd0);
        chk("R12 off in free mode", {31'd0, alm_mk_loss}, 32'd0);

        summary();
        $finish;
    end
endmodule